// File: doc/BRIEF.md
# Lamp Current Overdrive Controller with Auto-Off Timer

This block lets a lamp driver push extra current through cold lamps so they warm up quickly. While overdrive is requested, it raises the regulation threshold handed to the current loop by a programmable factor between 112.5% and 200% of the nominal value, in eighths. The level input may be moved at any time, so software can step the brightness back toward nominal after warm-up without a visible jump.

An optional timer ends the boost by itself. It counts lamp cycles, marked by a one-cycle tick, while overdrive is active. A 4-bit code selects the run time in units of a fixed number of lamp cycles. With the default unit of 4,500,000 cycles and a 50 kHz lamp, one unit is 90 seconds. Once the timer has ended a boost, overdrive stays off until the request is withdrawn and given again. The analog loop and any register access sit outside this block.

Top module: `lamp_overdrive_ctrl`

## Requirements
- R1: Overdrive becomes active on the clock edge that first samples either the software enable or the enable pin high while idle. `od_active_o` is high from that edge on.
- R2: While active, `thr_o` equals floor(nominal × (9 + level) / 8). Level codes 0 to 7 map to 112.5%, 125%, 137.5%, 150%, 162.5%, 175%, 187.5% and 200%.
- R3: While not active, `thr_o` equals the nominal code sampled on the previous edge.
- R4: A level change while active shows up in `thr_o` one cycle later and does not interrupt the active state.
- R5: Timeout code 0 disables the timer. Overdrive then stays active for any number of ticks.
- R6: For timeout code n in 1 to 14, the edge that samples the (n × UNIT_CYCLES)-th tick counted while active clears `od_active_o`.
- R7: Timeout codes above 14 behave like code 14.
- R8: After the timer ends a boost, overdrive stays off while the request stays high, whatever the ticks do. Dropping and reasserting the request restarts overdrive with the timer counted from zero.
- R9: When both enables are low at an edge, `od_active_o` is low after that edge. A partial timer count is discarded.
- R10: Only ticks sampled while active advance the timer. Cycles without a tick leave it unchanged.
- R11: After reset, `od_active_o` is 0 and `thr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nom_thr_i | input | THR_W | Nominal regulation threshold code |
| od_level_i | input | LVL_W | Overdrive level, 0 = 112.5% up to 7 = 200% |
| od_en_bit_i | input | 1 | Software overdrive request |
| od_en_pin_i | input | 1 | Pin overdrive request |
| tmo_code_i | input | TO_W | Auto-off time in units; 0 = timer off |
| lamp_tick_i | input | 1 | One-cycle pulse per lamp cycle |
| thr_o | output | THR_W+1 | Threshold passed to the current loop |
| od_active_o | output | 1 | Overdrive currently applied |

## Verification
The bench runs every nominal code of a 6-bit configuration against every level, both active and idle. A scaler that drops a shifted partial product, or a design that rounds instead of truncating, shows a wrong code for some pairs. It runs every timeout code with a three-cycle unit and samples both the last tick that should leave overdrive on and the tick that should end it. An off-by-one count, a missing clamp at code 15, or a timer that also counts idle ticks or tickless cycles fails there. It also checks that a boost which has timed out is not revived by a held request, and that a withdrawn request throws away a partial count.

// File: rtl/lod_pkg.sv
package lod_pkg;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_RUN  = 2'd1,
        ARM_DONE = 2'd2
    } arm_st_e;

endpackage

// File: rtl/lod_scale.sv
module lod_scale #(
    parameter int THR_W = 10,
    parameter int LVL_W = 3
) (
    input  logic [THR_W-1:0] nom_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [THR_W:0]   scaled_o
);
    localparam int MW = LVL_W + 1;
    localparam int PW = THR_W + LVL_W + 2;

    logic [MW-1:0] mul;
    logic [PW-1:0] acc [0:MW];
    logic [PW-1:0] total;

    assign mul    = {1'b0, lvl_i} + MW'(1);
    assign acc[0] = '0;

    for (genvar i = 0; i < MW; i++) begin : g_pp
        assign acc[i+1] = acc[i] + (mul[i] ? (PW'(nom_i) << i) : '0);
    end

    assign total    = (PW'(nom_i) << LVL_W) + acc[MW];
    assign scaled_o = (THR_W+1)'(total >> LVL_W);

    always_comb begin
        a_r2_not_below_nominal: assert (scaled_o >= (THR_W+1)'(nom_i));
        a_r2_not_above_double:  assert (scaled_o <= ((THR_W+1)'(nom_i) << 1));
    end
endmodule

// File: rtl/lod_timer.sv
module lod_timer #(
    parameter int TO_W        = 4,
    parameter int UNIT_CYCLES = 4_500_000,
    parameter int MAX_UNITS   = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            tick_i,
    input  logic [TO_W-1:0] code_i,
    output logic            expire_o
);
    localparam int PRE_W  = $clog2(UNIT_CYCLES + 1);
    localparam int UNIT_W = $clog2(MAX_UNITS + 2);
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(UNIT_CYCLES - 1);
    localparam logic [UNIT_W-1:0] UNIT_MAX = UNIT_W'(MAX_UNITS);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [UNIT_W-1:0] units;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [UNIT_W-1:0] limit;
    logic              wrap;
    logic [UNIT_W-1:0] units_nxt;

    always_comb begin
        if (32'(code_i) > MAX_UNITS) limit = UNIT_MAX;
        else                         limit = UNIT_W'(code_i);

        wrap      = run_i && tick_i && (tmr_q.pre == PRE_LAST);
        units_nxt = (tmr_q.units == UNIT_MAX) ? UNIT_MAX : tmr_q.units + UNIT_W'(1);
        expire_o  = wrap && (limit != '0) && (units_nxt >= limit);

        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d = '0;
        end else if (tick_i) begin
            if (wrap) begin
                tmr_d.pre   = '0;
                tmr_d.units = units_nxt;
            end else begin
                tmr_d.pre = tmr_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    a_r7_units_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.units <= UNIT_MAX);

    a_r10_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(tmr_q));

    a_r6_prescale_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.pre <= PRE_LAST);
endmodule

// File: rtl/lod_arm.sv
module lod_arm
    import lod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic expire_i,
    output logic active_o,
    output logic active_nxt_o
);
    typedef struct packed {
        arm_st_e st;
    } arm_t;

    arm_t arm_d, arm_q;

    always_comb begin
        arm_d = arm_q;
        unique case (arm_q.st)
            ARM_IDLE: if (req_i) arm_d.st = ARM_RUN;
            ARM_RUN: begin
                if (!req_i)        arm_d.st = ARM_IDLE;
                else if (expire_i) arm_d.st = ARM_DONE;
            end
            ARM_DONE: if (!req_i) arm_d.st = ARM_IDLE;
            default: arm_d.st = ARM_IDLE;
        endcase
        active_o     = (arm_q.st == ARM_RUN);
        active_nxt_o = (arm_d.st == ARM_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q.st <= ARM_IDLE;
        else        arm_q    <= arm_d;
    end

    a_r1_request_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q.st == ARM_IDLE && req_i) |=> active_o);

    a_r8_done_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q.st == ARM_DONE && req_i) |=> !active_o);

    a_r9_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !active_o);
endmodule

// File: rtl/lamp_overdrive_ctrl.sv
module lamp_overdrive_ctrl #(
    parameter int THR_W       = 10,
    parameter int LVL_W       = 3,
    parameter int TO_W        = 4,
    parameter int UNIT_CYCLES = 4_500_000,
    parameter int MAX_UNITS   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] nom_thr_i,
    input  logic [LVL_W-1:0] od_level_i,
    input  logic             od_en_bit_i,
    input  logic             od_en_pin_i,
    input  logic [TO_W-1:0]  tmo_code_i,
    input  logic             lamp_tick_i,
    output logic [THR_W:0]   thr_o,
    output logic             od_active_o
);
    typedef struct packed {
        logic [THR_W:0] thr;
    } out_t;

    out_t out_d, out_q;
    logic           req;
    logic           active;
    logic           active_nxt;
    logic           expire;
    logic [THR_W:0] scaled;

    assign req = od_en_bit_i | od_en_pin_i;

    lod_scale #(.THR_W(THR_W), .LVL_W(LVL_W)) u_scale (
        .nom_i    (nom_thr_i),
        .lvl_i    (od_level_i),
        .scaled_o (scaled)
    );

    lod_timer #(.TO_W(TO_W), .UNIT_CYCLES(UNIT_CYCLES), .MAX_UNITS(MAX_UNITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (active),
        .tick_i   (lamp_tick_i),
        .code_i   (tmo_code_i),
        .expire_o (expire)
    );

    lod_arm u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .expire_i     (expire),
        .active_o     (active),
        .active_nxt_o (active_nxt)
    );

    always_comb begin
        out_d     = out_q;
        out_d.thr = active_nxt ? scaled : (THR_W+1)'(nom_thr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign thr_o       = out_q.thr;
    assign od_active_o = active;

    a_r3_idle_passes_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !od_active_o) |-> (thr_o == (THR_W+1)'($past(nom_thr_i))));

    a_r2_active_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && od_active_o) |-> (thr_o >= (THR_W+1)'($past(nom_thr_i))));
endmodule

// File: tb/sim_lamp_overdrive_ctrl.sv
module sim_lamp_overdrive_ctrl;
    localparam int PER   = 10;
    localparam int THR_W = 6;
    localparam int LVL_W = 3;
    localparam int TO_W  = 4;
    localparam int UNIT  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [THR_W-1:0] nom = '0;
    logic [LVL_W-1:0] lvl = '0;
    logic             en_bit = 1'b0;
    logic             en_pin = 1'b0;
    logic [TO_W-1:0]  code = '0;
    logic             tick = 1'b0;
    logic [THR_W:0]   thr;
    logic             act;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(PER/2) clk = ~clk;

    lamp_overdrive_ctrl #(
        .THR_W(THR_W), .LVL_W(LVL_W), .TO_W(TO_W),
        .UNIT_CYCLES(UNIT), .MAX_UNITS(14)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .nom_thr_i(nom), .od_level_i(lvl),
        .od_en_bit_i(en_bit), .od_en_pin_i(en_pin), .tmo_code_i(code),
        .lamp_tick_i(tick), .thr_o(thr), .od_active_o(act)
    );

    task automatic chk(input int actual, input int expected, input string tag);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick_one();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic drop_all();
        en_bit = 1'b0;
        en_pin = 1'b0;
        cyc();
    endtask

    function automatic int units_of(input int c);
        return (c > 14) ? 14 : c;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PER * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc();
        // R11: reset values
        chk(int'(act), 0, "R11 active after reset");
        chk(int'(thr), 0, "R11 threshold after reset");
        rst_n = 1'b1;
        cyc();

        // R3: idle passes nominal for every code
        for (int v = 0; v < (1 << THR_W); v++) begin
            nom = THR_W'(v);
            lvl = LVL_W'(v % 8);
            cyc();
            chk(int'(thr), v, "R3 idle threshold");
            chk(int'(act), 0, "R3 idle flag");
        end

        // R1 via bit, R2 exhaustive with timer off
        code = '0;
        en_bit = 1'b1;
        cyc();
        chk(int'(act), 1, "R1 enable bit arms");
        for (int v = 0; v < (1 << THR_W); v++) begin
            for (int l = 0; l < 8; l++) begin
                nom = THR_W'(v);
                lvl = LVL_W'(l);
                cyc();
                chk(int'(thr), (v * (9 + l)) / 8, "R2 scaled threshold");
            end
        end

        // R4: level stepped down on the fly
        nom = THR_W'(40);
        for (int l = 7; l >= 0; l--) begin
            lvl = LVL_W'(l);
            cyc();
            chk(int'(thr), (40 * (9 + l)) / 8, "R4 level change");
            chk(int'(act), 1, "R4 stays active");
        end

        // R5: timer off ignores many ticks
        for (int i = 0; i < 100; i++) tick_one();
        chk(int'(act), 1, "R5 code 0 never expires");
        drop_all();
        chk(int'(act), 0, "R9 drop clears active");
        chk(int'(thr), 40, "R9 nominal after drop");

        // R6/R7: every timeout code, alternating enable source
        for (int c = 1; c < 16; c++) begin
            int n;
            n = units_of(c) * UNIT;
            code = TO_W'(c);
            if (c % 2 == 0) en_pin = 1'b1; else en_bit = 1'b1;
            cyc();
            chk(int'(act), 1, "R1 armed for timer run");
            for (int i = 0; i < n - 1; i++) tick_one();
            chk(int'(act), 1, (c > 14) ? "R7 one tick before end" : "R6 one tick before end");
            tick_one();
            chk(int'(act), 0, (c > 14) ? "R7 expired at clamp" : "R6 expired on last tick");
            chk(int'(thr), 40, "R6 nominal after expiry");
            drop_all();
        end

        // R8: held request does not revive, re-arm restarts count
        code = TO_W'(1);
        en_pin = 1'b1;
        cyc();
        for (int i = 0; i < UNIT; i++) tick_one();
        chk(int'(act), 0, "R8 expired");
        for (int i = 0; i < 10; i++) tick_one();
        en_bit = 1'b1;
        cyc();
        chk(int'(act), 0, "R8 held request stays off");
        drop_all();
        en_bit = 1'b1;
        cyc();
        chk(int'(act), 1, "R8 re-arm");
        for (int i = 0; i < UNIT - 1; i++) tick_one();
        chk(int'(act), 1, "R8 fresh count before end");
        tick_one();
        chk(int'(act), 0, "R8 fresh count ends");
        drop_all();

        // R9: partial count discarded on drop
        code = TO_W'(2);
        en_bit = 1'b1;
        cyc();
        for (int i = 0; i < 2 * UNIT - 1; i++) tick_one();
        drop_all();
        en_bit = 1'b1;
        cyc();
        for (int i = 0; i < 2 * UNIT - 1; i++) tick_one();
        chk(int'(act), 1, "R9 partial count discarded");
        tick_one();
        chk(int'(act), 0, "R9 full count after re-arm");
        drop_all();

        // R10: tickless cycles and idle ticks do not count
        for (int i = 0; i < 7; i++) tick_one();
        code = TO_W'(1);
        en_bit = 1'b1;
        cyc();
        for (int i = 0; i < 20; i++) cyc();
        chk(int'(act), 1, "R10 tickless cycles ignored");
        for (int i = 0; i < UNIT - 1; i++) tick_one();
        chk(int'(act), 1, "R10 idle ticks ignored");
        tick_one();
        chk(int'(act), 0, "R10 expiry on counted ticks");
        drop_all();

        finish_run();
    end
endmodule